// File: doc/BRIEF.md
# Sequential Floating-Point Divider

This block divides one 32-bit floating-point word by another, one quotient bit per clock. The word is stored with its 16-bit halves swapped. Bits 31:16 hold the low 16 fraction bits. Bit 15 is the sign. Bits 14:7 hold an 8-bit exponent biased by 128. Bits 6:0 hold the high 7 fraction bits. A hidden leading one is implied, so the operand mantissa is the 24-bit value {1, bits 6:0, bits 31:16}.

A pulse on `start_i` while the unit is idle captures both operands and the underflow enable. Operands that need no division finish at once: a reserved encoding, a zero divisor or a zero dividend. Every other case runs a restoring fraction divide that develops up to 26 quotient bits, which is two more than the mantissa holds. The divide stops early when the partial remainder becomes zero. The quotient is then left-justified by the number of steps actually run, normalized, rounded and packed. The result and the fault flags appear together with a one-cycle `done_o` pulse and hold until the next pulse.

Top module: `fdiv_seq`

## Requirements
- R1: If either operand has sign bit 15 set and exponent field 14:7 equal to zero, `rsvd_o` is set, the result is zero and no other flag is set. This case takes priority over every other case.
- R2: If the divisor has exponent field zero and sign clear, and R1 does not apply, `dzero_o` is set and the result is zero. This holds whatever the dividend is, including a zero dividend.
- R3: A dividend with exponent field zero and sign clear, divided by a valid nonzero divisor, gives result zero with no flag set.
- R4: The sign bit 15 of a nonzero result is the XOR of the two operand signs.
- R5: The result mantissa comes from the binary quotient of the mantissas, truncated to 26 significant bits. The bit below the 24-bit mantissa is added to its LSB, so ties round up.
- R6: The result exponent is the dividend exponent minus the divisor exponent plus 129. It is one lower when the dividend mantissa is smaller than the divisor mantissa, and one higher when rounding carries out of the mantissa.
- R7: A result exponent above 255 sets `ovf_o` and gives result zero.
- R8: A result exponent of zero or below gives result zero. `unf_o` is set only if `unf_en_i` was high on the cycle `start_i` was taken.
- R9: Count the clock edge that takes `start_i` as edge 0. `done_o` rises after edge 1 for the cases in R1, R2 and R3, and after edge i+1 for a divide that runs i steps. i is 26, or fewer when the remainder becomes zero after step i.
- R10: `start_i` is ignored while an operation is in progress. The running operation completes with its own operands, and only one `done_o` pulse is produced.
- R11: After reset, `done_o`, `result_o` and all flags are zero. `done_o` is high for exactly one cycle per operation. The result and flags hold their values between `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| dividend_i | input | 32 | Dividend word |
| divisor_i | input | 32 | Divisor word |
| unf_en_i | input | 1 | Report underflow on `unf_o` |
| result_o | output | 32 | Quotient word, zero on any fault |
| done_o | output | 1 | One-cycle completion pulse |
| dzero_o | output | 1 | Divide by zero |
| rsvd_o | output | 1 | Reserved operand |
| ovf_o | output | 1 | Exponent overflow |
| unf_o | output | 1 | Exponent underflow (when enabled) |

## Verification
The hardest behaviour to reach from the ports is the early exit of the divide loop at each possible step count. That exit is what exposes a wrong justify shift or a wrong latched count. The mantissa sweep pairs a divisor of exactly 1.0, a divisor with only the top fraction bit set and equal mantissas against many dividends. The exact quotients that result stop the loop after anywhere from one step to all 26 steps, and the bench checks both the value and the cycle of `done_o`. Two exponent sweeps against extreme divisor exponents push results across the overflow and underflow edges with the enable toggled. A start pulse issued in mid-divide checks that the running operation is not disturbed.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int WORD_W    = 32;
  localparam int EXP_W     = 8;
  localparam int HI_FRAC_W = 7;
  localparam int LO_FRAC_W = 16;
  localparam int FRAC_W    = HI_FRAC_W + LO_FRAC_W;
  localparam int MANT_W    = FRAC_W + 1;
  localparam int GUARD_W   = 2;
  localparam int QUO_W     = MANT_W + GUARD_W;
  localparam int REM_W     = MANT_W + 1;
  localparam int CNT_W     = $clog2(QUO_W + 1);
  localparam int EXT_W     = EXP_W + 3;
  localparam int EXP_LSB   = HI_FRAC_W;
  localparam int SIGN_POS  = EXP_LSB + EXP_W;
  localparam int LO_LSB    = WORD_W - LO_FRAC_W;
  localparam int EXP_BIAS  = 1 << (EXP_W - 1);
  localparam int EXP_MAX   = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
  } fop_t;

  typedef enum logic [1:0] {RK_DIV, RK_ZERO, RK_DZ, RK_RSVD} rkind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ITER, ST_PACK} st_t;
endpackage

// File: rtl/fdiv_unpack.sv
module fdiv_unpack
  import fdiv_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output fop_t              op_o,
  output logic              zero_o,
  output logic              rsvd_o
);
  logic exp_nz;

  assign op_o.sign = word_i[SIGN_POS];
  assign op_o.expo = word_i[SIGN_POS-1:EXP_LSB];
  assign op_o.mant = {1'b1, word_i[HI_FRAC_W-1:0], word_i[WORD_W-1:LO_LSB]};
  assign exp_nz    = |word_i[SIGN_POS-1:EXP_LSB];
  assign zero_o    = !exp_nz && !word_i[SIGN_POS];
  assign rsvd_o    = !exp_nz && word_i[SIGN_POS];
endmodule

// File: rtl/fdiv_step.sv
module fdiv_step
  import fdiv_pkg::*;
(
  input  logic [REM_W-1:0]  rem_i,
  input  logic [MANT_W-1:0] dvs_i,
  input  logic [QUO_W-1:0]  quo_i,
  output logic [REM_W-1:0]  rem_o,
  output logic [QUO_W-1:0]  quo_o
);
  logic             ge;
  logic [REM_W-1:0] dvs_ext;
  logic [REM_W-1:0] diff;

  assign dvs_ext = {1'b0, dvs_i};
  assign ge      = rem_i >= dvs_ext;
  assign diff    = ge ? rem_i - dvs_ext : rem_i;
  // diff < divisor, so the doubled remainder never overflows REM_W
  assign rem_o   = diff << 1;
  assign quo_o   = {quo_i[QUO_W-2:0], ge};
endmodule

// File: rtl/fdiv_pack.sv
module fdiv_pack
  import fdiv_pkg::*;
(
  input  logic                    sign_i,
  input  logic signed [EXT_W-1:0] exp_i,
  input  logic [QUO_W-1:0]        quo_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    unf_en_i,
  output logic [WORD_W-1:0]       word_o,
  output logic                    ovf_o,
  output logic                    unf_o
);
  localparam logic signed [EXT_W-1:0] EMAX_S = EXT_W'(EXP_MAX);
  localparam logic signed [EXT_W-1:0] ZERO_S = '0;

  logic [CNT_W-1:0]        shamt;
  logic [QUO_W-1:0]        qj, qn;
  logic                    hi_ok, carry, ovf, uflow;
  logic [MANT_W:0]         msum;
  logic [MANT_W-1:0]       mant;
  logic signed [EXT_W-1:0] e1, e2;
  logic                    unused_bits;

  // justify by the number of steps actually run
  assign shamt = CNT_W'(QUO_W) - cnt_i;
  assign qj    = quo_i << shamt;
  assign hi_ok = qj[QUO_W-1];
  assign qn    = hi_ok ? qj : qj << 1;
  assign e1    = exp_i - EXT_W'(!hi_ok);

  assign msum  = {1'b0, qn[QUO_W-1:GUARD_W]} + (MANT_W+1)'(qn[GUARD_W-1]);
  assign carry = msum[MANT_W];
  assign mant  = carry ? msum[MANT_W:1] : msum[MANT_W-1:0];
  assign e2    = e1 + EXT_W'(carry);

  assign ovf   = e2 > EMAX_S;
  assign uflow = e2 <= ZERO_S;

  assign word_o = (ovf || uflow) ? '0 :
                  {mant[LO_FRAC_W-1:0], sign_i, e2[EXP_W-1:0], mant[FRAC_W-1:LO_FRAC_W]};
  assign ovf_o  = ovf;
  assign unf_o  = uflow && unf_en_i;

  assign unused_bits = ^{qn[GUARD_W-2:0], mant[MANT_W-1]};
endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
  import fdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] dividend_i,
  input  logic [WORD_W-1:0] divisor_i,
  input  logic              unf_en_i,
  output logic [WORD_W-1:0] result_o,
  output logic              done_o,
  output logic              dzero_o,
  output logic              rsvd_o,
  output logic              ovf_o,
  output logic              unf_o
);
  st_t                     state_q;
  rkind_t                  kind_q, kind_d;
  fop_t                    dvd_op, dvs_op;
  logic                    dvd_zero, dvd_rsvd, dvs_zero, dvs_rsvd;

  logic [REM_W-1:0]        rem_q, rem_nx;
  logic [MANT_W-1:0]       dvs_q;
  logic [QUO_W-1:0]        quo_q, quo_nx;
  logic [CNT_W-1:0]        cnt_q;
  logic                    sign_q, unf_en_q;
  logic signed [EXT_W-1:0] exp_q, exp_start;
  logic                    last_step, exact;

  logic [WORD_W-1:0]       pk_word;
  logic                    pk_ovf, pk_unf;

  logic [WORD_W-1:0]       result_q;
  logic                    done_q, dz_q, rsvd_q, ovf_q, unf_q;

  fdiv_unpack u_unp_dvd (
    .word_i (dividend_i),
    .op_o   (dvd_op),
    .zero_o (dvd_zero),
    .rsvd_o (dvd_rsvd)
  );

  fdiv_unpack u_unp_dvs (
    .word_i (divisor_i),
    .op_o   (dvs_op),
    .zero_o (dvs_zero),
    .rsvd_o (dvs_rsvd)
  );

  fdiv_step u_step (
    .rem_i (rem_q),
    .dvs_i (dvs_q),
    .quo_i (quo_q),
    .rem_o (rem_nx),
    .quo_o (quo_nx)
  );

  fdiv_pack u_pack (
    .sign_i   (sign_q),
    .exp_i    (exp_q),
    .quo_i    (quo_q),
    .cnt_i    (cnt_q),
    .unf_en_i (unf_en_q),
    .word_o   (pk_word),
    .ovf_o    (pk_ovf),
    .unf_o    (pk_unf)
  );

  assign exp_start = EXT_W'(dvd_op.expo) - EXT_W'(dvs_op.expo) + EXT_W'(EXP_BIAS + 1);
  assign last_step = cnt_q == CNT_W'(QUO_W - 1);
  assign exact     = rem_nx == '0;

  always_comb begin
    if (dvd_rsvd || dvs_rsvd) kind_d = RK_RSVD;
    else if (dvs_zero)        kind_d = RK_DZ;
    else if (dvd_zero)        kind_d = RK_ZERO;
    else                      kind_d = RK_DIV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_q   <= RK_DIV;
      rem_q    <= '0;
      dvs_q    <= '0;
      quo_q    <= '0;
      cnt_q    <= '0;
      sign_q   <= 1'b0;
      exp_q    <= '0;
      unf_en_q <= 1'b0;
      result_q <= '0;
      done_q   <= 1'b0;
      dz_q     <= 1'b0;
      rsvd_q   <= 1'b0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            kind_q   <= kind_d;
            rem_q    <= {1'b0, dvd_op.mant};
            dvs_q    <= dvs_op.mant;
            quo_q    <= '0;
            cnt_q    <= '0;
            sign_q   <= dvd_op.sign ^ dvs_op.sign;
            exp_q    <= exp_start;
            unf_en_q <= unf_en_i;
            state_q  <= (kind_d == RK_DIV) ? ST_ITER : ST_PACK;
          end
        end
        ST_ITER: begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt_q <= cnt_q + CNT_W'(1);
          if (exact || last_step) state_q <= ST_PACK;
        end
        ST_PACK: begin
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
          result_q <= '0;
          dz_q     <= 1'b0;
          rsvd_q   <= 1'b0;
          ovf_q    <= 1'b0;
          unf_q    <= 1'b0;
          case (kind_q)
            RK_RSVD: rsvd_q <= 1'b1;
            RK_DZ:   dz_q   <= 1'b1;
            RK_ZERO: ;
            default: begin
              result_q <= pk_word;
              ovf_q    <= pk_ovf;
              unf_q    <= pk_unf;
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;
  assign dzero_o  = dz_q;
  assign rsvd_o   = rsvd_q;
  assign ovf_o    = ovf_q;
  assign unf_o    = unf_q;
endmodule

// File: rtl/fdiv_seq_chk.sv
module fdiv_seq_chk
  import fdiv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] result_o,
  input logic              done_o,
  input logic              dzero_o,
  input logic              rsvd_o,
  input logic              ovf_o,
  input logic              unf_o
);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({result_o, dzero_o, rsvd_o, ovf_o, unf_o}));

  // R7
  one_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dzero_o, rsvd_o, ovf_o, unf_o}));

  // R8
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dzero_o || rsvd_o || ovf_o || unf_o) |-> (result_o == '0));

  // R6
  exp_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o != '0) |-> (result_o[SIGN_POS-1:EXP_LSB] != '0));
endmodule

bind fdiv_seq fdiv_seq_chk u_chk (.*);

// File: tb/fdiv_seq_test.sv
module fdiv_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fu = 1'b0;
  logic [31:0] dvd = '0;
  logic [31:0] dvs = '0;
  logic [31:0] result;
  logic        done, dz, rv, ov, uf;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fdiv_seq uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .dividend_i (dvd),
    .divisor_i  (dvs),
    .unf_en_i   (fu),
    .result_o   (result),
    .done_o     (done),
    .dzero_o    (dz),
    .rsvd_o     (rv),
    .ovf_o      (ov),
    .unf_o      (uf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exv);
    end
  endtask

  function automatic logic [31:0] mk(input bit s, input logic [7:0] e, input logic [22:0] f);
    return {f[15:0], s, e, f[22:16]};
  endfunction

  function automatic logic [22:0] pick(input int k);
    case (k)
      0: return 23'h000000;
      1: return 23'h7FFFFF;
      2: return 23'h400000;
      3: return 23'h000001;
      4: return 23'h200000;
      default: return 23'((k * 32'h0013579B) ^ (k << 17) ^ 32'h0002A5A5);
    endcase
  endfunction

  // expected {result, dz, rsvd, ovf, unf} and latency in negedges
  task automatic model(input logic [31:0] a, input logic [31:0] b, input bit en,
                       output logic [35:0] ev, output int lat, output string req);
    bit sa, sb;
    int ea, eb, e, tz;
    longint ma, mb, num, qr, q, m;
    sa = a[15]; sb = b[15];
    ea = int'(a[14:7]); eb = int'(b[14:7]);
    ma = longint'({1'b1, a[6:0], a[31:16]});
    mb = longint'({1'b1, b[6:0], b[31:16]});
    lat = 2;
    if ((ea == 0 && sa) || (eb == 0 && sb)) begin
      ev = {32'h0, 4'b0100}; req = "R1";
    end else if (eb == 0) begin
      ev = {32'h0, 4'b1000}; req = "R2";
    end else if (ea == 0) begin
      ev = {32'h0, 4'b0000}; req = "R3";
    end else begin
      num = ma << 25;
      qr  = num / mb;
      if (num % mb == 0) begin
        tz = 0;
        while (((qr >> tz) & 1) == 0) tz++;
        lat = 26 - tz + 2;
      end else lat = 28;
      if (qr >= (longint'(1) << 25)) begin
        q = qr; e = ea - eb + 129;
      end else begin
        q = (ma << 26) / mb; e = ea - eb + 128;
      end
      m = (q >> 2) + ((q >> 1) & 1);
      if (m == (longint'(1) << 24)) begin
        m = longint'(1) << 23; e++;
      end
      if (e > 255) begin
        ev = {32'h0, 4'b0010}; req = "R7";
      end else if (e <= 0) begin
        ev = {32'h0, 3'b000, en}; req = "R8";
      end else begin
        ev = {mk(sa ^ sb, e[7:0], m[22:0]), 4'b0000}; req = "R5 R6";
      end
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input bit en);
    logic [35:0] ev, got;
    int lat, n;
    string req;
    model(a, b, en, ev, lat, req);
    @(negedge clk);
    dvd = a; dvs = b; fu = en; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    got = {result, dz, rv, ov, uf};
    chk(got === ev, req, 64'(got), 64'(ev));
    if (req == "R5 R6")
      chk(result[15] === (a[15] ^ b[15]), "R4", 64'(result[15]), 64'(a[15] ^ b[15]));
    chk(n == lat, "R9 latency", 64'(n), 64'(lat));
    @(negedge clk);
    chk(!done && ({result, dz, rv, ov, uf} === got), "R11 pulse/hold",
        64'({done, result, dz, rv, ov, uf}), 64'({1'b0, got}));
  endtask

  task automatic busy_test();
    logic [31:0] a, b;
    logic [35:0] ev, got;
    int lat, n;
    bit extra;
    string req;
    a = mk(0, 8'd140, 23'h123456);
    b = mk(1, 8'd120, 23'h654321);
    model(a, b, 1'b0, ev, lat, req);
    @(negedge clk);
    dvd = a; dvs = b; fu = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    repeat (5) begin @(negedge clk); n++; end
    dvd = mk(0, 8'd0, 23'h0); dvs = mk(0, 8'd0, 23'h0); start = 1'b1;
    @(negedge clk); n++;
    start = 1'b0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    got = {result, dz, rv, ov, uf};
    chk(got === ev, "R10 result", 64'(got), 64'(ev));
    chk(n == lat, "R10 latency", 64'(n), 64'(lat));
    extra = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    chk(!extra, "R10 no second done", 64'(extra), 64'(0));
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({done, result, dz, rv, ov, uf} === '0, "R11 reset",
        64'({done, result, dz, rv, ov, uf}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // special encodings and their priority
    run(mk(1, 8'd0, 23'h001234), mk(0, 8'd130, 23'h000005), 1'b0);
    run(mk(0, 8'd130, 23'h0ABCDE), mk(1, 8'd0, 23'h000000), 1'b0);
    run(mk(1, 8'd0, 23'h7FFFFF), mk(0, 8'd0, 23'h000000), 1'b1);
    run(mk(0, 8'd0, 23'h000000), mk(1, 8'd0, 23'h000001), 1'b0);
    run(mk(0, 8'd140, 23'h000007), mk(0, 8'd0, 23'h000055), 1'b0);
    run(mk(0, 8'd0, 23'h000000), mk(0, 8'd0, 23'h000000), 1'b0);
    run(mk(0, 8'd0, 23'h0003FF), mk(1, 8'd129, 23'h000003), 1'b1);

    // rounding carry cases
    run(mk(0, 8'd200, 23'h7FFFFF), mk(0, 8'd100, 23'h000001), 1'b0);
    run(mk(1, 8'd254, 23'h7FFFFF), mk(0, 8'd129, 23'h000001), 1'b0);
    run(mk(0, 8'd127, 23'h7FFFFF), mk(0, 8'd255, 23'h000001), 1'b1);

    // mantissa sweep under three exponent pairs
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          logic [7:0] ea, eb;
          ea = (p == 0) ? 8'd130 : (p == 1) ? 8'd129 : 8'd200;
          eb = (p == 0) ? 8'd129 : (p == 1) ? 8'd131 : 8'd60;
          run(mk(i[0], ea, pick(i)), mk(j[1], eb, pick(j)), 1'b0);
        end
      end
    end

    // exponent sweeps across overflow and underflow
    for (int e = 1; e < 256; e++) begin
      run(mk(e[0], 8'(e), pick(e % 16)), mk(0, 8'd1, pick((e + 3) % 16)), e[1]);
      run(mk(0, 8'(e), pick((e + 5) % 16)), mk(1, 8'd255, pick(e % 16)), e[0]);
    end

    busy_test();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule